// File: doc/BRIEF.md
# Tree-structured min-sum soft-output decoder

This block takes the branch metrics of a two-state trellis over a block of eight steps and returns, for every step, two soft outputs. One is the smallest path metric among all paths whose input bit at that step is 0. The other is the same minimum for paths whose bit is 1. Every path starts in state 0 and may end in either state. Branch-metric generation and turbo iteration control sit outside the block.

It has no serial add-compare-select recursion. Each step is held as a 2x2 state-to-state metric matrix, and the matrices are merged with a min-plus product, which is associative. A parallel-prefix scan of log2(K) registered levels builds the merged metric for every prefix segment and every suffix segment. One more registered stage joins the prefix, the branch of the step itself and the suffix into the two minima for each step. There is no feedback anywhere, so a new block can enter on every cycle.

Both stream edges use valid/ready. The whole pipeline advances only when the output register is empty or is being taken. A result that is held back freezes every stage, and while that lasts `in_ready` stays low. Data is never dropped, never duplicated and never reordered.

Top module: `tree_siso`

## Requirements
- R1: While `out_valid` is high and `out_ready` is low, `in_ready` is low, and `out_valid`, `out_m0` and `out_m1` keep their values at the next clock edge.
- R2: With `out_ready` held high, a block accepted at a clock edge appears on `out_valid` after exactly log2(K_STEPS)+1 = 4 clock edges. A new block is accepted on every cycle, and no more than 4 blocks are ever in flight.
- R3: `in_bm[(k*4 + i*2 + j)*8 +: 8]` is the unsigned metric for step k going from state i to state j. Taking that branch means the input bit of step k equals j.
- R4: `out_m0[k*8 +: 8]` and `out_m1[k*8 +: 8]` are the minimum, over all paths with bit k equal to 0 or to 1 respectively, of the sum of the path's eight branch metrics. The end state is free.
- R5: Every path starts in state 0. A path starting in state 1 is treated as costing 255.
- R6: Every sum saturates at 255, so an output never wraps.
- R7: Each accepted block gives exactly one result, and results leave in the order the blocks were accepted.
- R8: During and right after reset, `out_valid` is low and `in_ready` is high.
- R9: For every valid result, min(`out_m0[k]`, `out_m1[k]`) is the same for all k, and it equals the best overall path metric.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A block of branch metrics is offered |
| in_ready | output | 1 | The block offered is taken at this edge |
| in_bm | input | K_STEPS*32 | Branch metrics, laid out as in R3 |
| out_valid | output | 1 | A result is presented |
| out_ready | input | 1 | The downstream side takes the result |
| out_m0 | output | K_STEPS*8 | Per-step minimum with the bit equal to 0 |
| out_m1 | output | K_STEPS*8 | Per-step minimum with the bit equal to 1 |

## Verification
The main function is tried with several metric patterns, and each one separates a different kind of fault:
- All-zero metrics catch any offset added to the sums.
- Metrics that favour bit 1 everywhere give known results of 0 and 5, which exposes a swapped bit or a mislabelled transition.
- Metrics of 200 on every branch push every sum into saturation.
- A trap at step 0, where leaving state 1 is free, fails if the start state is not pinned.
- Random patterns in a full range and in a small range are compared with a serial forward/backward reference. These catch scan-index and distance errors in the tree, because a wrong neighbour changes only some of the steps.

Back-pressure runs show the difference between a proper stall and lost or repeated data.

// File: rtl/tsiso_pkg.sv
package tsiso_pkg;
  localparam int MW     = 8;
  localparam int NSTATE = 2;
  localparam int NTRANS = NSTATE * NSTATE;

  typedef logic [MW-1:0] metric_t;
  // state-to-state metric matrix, entry (from i, to j) at index i*NSTATE + j
  typedef metric_t [NTRANS-1:0] mat_t;

  function automatic metric_t sat_add(input metric_t a, input metric_t b);
    logic [MW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[MW] ? {MW{1'b1}} : s[MW-1:0];
  endfunction

  function automatic metric_t mmin(input metric_t a, input metric_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/tsiso_minplus.sv
// Min-plus product of two adjacent segment matrices: c = a then b.
module tsiso_minplus
  import tsiso_pkg::*;
(
  input  mat_t a,
  input  mat_t b,
  output mat_t c
);
  always_comb begin
    for (int i = 0; i < NSTATE; i++) begin
      for (int j = 0; j < NSTATE; j++) begin
        metric_t best;
        best = {MW{1'b1}};
        for (int s = 0; s < NSTATE; s++) begin
          best = mmin(best, sat_add(a[i*NSTATE+s], b[s*NSTATE+j]));
        end
        c[i*NSTATE+j] = best;
      end
    end
  end
endmodule

// File: rtl/tsiso_scan_level.sv
// One registered level of the prefix/suffix scan, merging at distance DIST.
module tsiso_scan_level
  import tsiso_pkg::*;
#(
  parameter int K_STEPS = 8,
  parameter int DIST    = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en,
  input  logic                 v_i,
  input  mat_t [K_STEPS-1:0]   pre_i,
  input  mat_t [K_STEPS-1:0]   suf_i,
  input  mat_t [K_STEPS-1:0]   bm_i,
  output logic                 v_o,
  output mat_t [K_STEPS-1:0]   pre_o,
  output mat_t [K_STEPS-1:0]   suf_o,
  output mat_t [K_STEPS-1:0]   bm_o
);
  mat_t [K_STEPS-1:0] pre_n;
  mat_t [K_STEPS-1:0] suf_n;

  generate
    for (genvar k = 0; k < K_STEPS; k++) begin : g_col
      if (k >= DIST) begin : g_pre_merge
        tsiso_minplus u_pre (.a(pre_i[k-DIST]), .b(pre_i[k]), .c(pre_n[k]));
      end else begin : g_pre_pass
        assign pre_n[k] = pre_i[k];
      end
      if (k + DIST < K_STEPS) begin : g_suf_merge
        tsiso_minplus u_suf (.a(suf_i[k]), .b(suf_i[k+DIST]), .c(suf_n[k]));
      end else begin : g_suf_pass
        assign suf_n[k] = suf_i[k];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      pre_o <= '0;
      suf_o <= '0;
      bm_o  <= '0;
    end else if (en) begin
      v_o   <= v_i;
      pre_o <= pre_n;
      suf_o <= suf_n;
      bm_o  <= bm_i;
    end
  end
endmodule

// File: rtl/tsiso_combine.sv
// Joins prefix state metrics, the step's own branch and the suffix minimum.
module tsiso_combine
  import tsiso_pkg::*;
#(
  parameter int K_STEPS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  logic                  v_i,
  input  mat_t    [K_STEPS-1:0] pre_i,
  input  mat_t    [K_STEPS-1:0] suf_i,
  input  mat_t    [K_STEPS-1:0] bm_i,
  output logic                  v_o,
  output metric_t [K_STEPS-1:0] m0_o,
  output metric_t [K_STEPS-1:0] m1_o
);
  metric_t [K_STEPS-1:0] m0_n;
  metric_t [K_STEPS-1:0] m1_n;
  logic unused_ends;

  // the full-block prefix and the suffix from step 0 are never needed
  assign unused_ends = ^{pre_i[K_STEPS-1], suf_i[0]};

  generate
    for (genvar k = 0; k < K_STEPS; k++) begin : g_step
      metric_t fwd0, fwd1, bwd0, bwd1;
      if (k == 0) begin : g_start
        assign fwd0 = '0;
        assign fwd1 = {MW{1'b1}};   // start state pinned to 0
      end else begin : g_fwd
        assign fwd0 = pre_i[k-1][0];
        assign fwd1 = pre_i[k-1][1];
      end
      if (k == K_STEPS - 1) begin : g_end
        assign bwd0 = '0;
        assign bwd1 = '0;
      end else begin : g_bwd
        assign bwd0 = mmin(suf_i[k+1][0], suf_i[k+1][1]);
        assign bwd1 = mmin(suf_i[k+1][NSTATE], suf_i[k+1][NSTATE+1]);
      end
      assign m0_n[k] = sat_add(mmin(sat_add(fwd0, bm_i[k][0]),
                                    sat_add(fwd1, bm_i[k][NSTATE])), bwd0);
      assign m1_n[k] = sat_add(mmin(sat_add(fwd0, bm_i[k][1]),
                                    sat_add(fwd1, bm_i[k][NSTATE+1])), bwd1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_o  <= 1'b0;
      m0_o <= '0;
      m1_o <= '0;
    end else if (en) begin
      v_o  <= v_i;
      m0_o <= m0_n;
      m1_o <= m1_n;
    end
  end
endmodule

// File: rtl/tree_siso.sv
module tree_siso
  import tsiso_pkg::*;
#(
  parameter int K_STEPS = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [K_STEPS*NTRANS*MW-1:0] in_bm,
  output logic                        out_valid,
  input  logic                        out_ready,
  output logic [K_STEPS*MW-1:0]       out_m0,
  output logic [K_STEPS*MW-1:0]       out_m1
);
  localparam int LEVELS = $clog2(K_STEPS);

  logic en;
  mat_t [K_STEPS-1:0] lvl_pre [LEVELS+1];
  mat_t [K_STEPS-1:0] lvl_suf [LEVELS+1];
  mat_t [K_STEPS-1:0] lvl_bm  [LEVELS+1];
  logic               lvl_v   [LEVELS+1];
  metric_t [K_STEPS-1:0] m0_q, m1_q;

  // the whole pipe moves together: only when the output slot frees up
  assign en       = out_ready || !out_valid;
  assign in_ready = en;

  assign lvl_pre[0] = in_bm;
  assign lvl_suf[0] = in_bm;
  assign lvl_bm[0]  = in_bm;
  assign lvl_v[0]   = in_valid;

  generate
    for (genvar l = 0; l < LEVELS; l++) begin : g_level
      tsiso_scan_level #(.K_STEPS(K_STEPS), .DIST(1 << l)) u_level (
        .clk(clk), .rst_n(rst_n), .en(en), .v_i(lvl_v[l]),
        .pre_i(lvl_pre[l]), .suf_i(lvl_suf[l]), .bm_i(lvl_bm[l]),
        .v_o(lvl_v[l+1]),
        .pre_o(lvl_pre[l+1]), .suf_o(lvl_suf[l+1]), .bm_o(lvl_bm[l+1])
      );
    end
  endgenerate

  tsiso_combine #(.K_STEPS(K_STEPS)) u_combine (
    .clk(clk), .rst_n(rst_n), .en(en), .v_i(lvl_v[LEVELS]),
    .pre_i(lvl_pre[LEVELS]), .suf_i(lvl_suf[LEVELS]), .bm_i(lvl_bm[LEVELS]),
    .v_o(out_valid), .m0_o(m0_q), .m1_o(m1_q)
  );

  assign out_m0 = m0_q;
  assign out_m1 = m1_q;
endmodule

// File: rtl/tsiso_checks.sv
module tsiso_checks
  import tsiso_pkg::*;
#(
  parameter int K_STEPS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic                  out_valid,
  input logic                  out_ready,
  input logic [K_STEPS*MW-1:0] out_m0,
  input logic [K_STEPS*MW-1:0] out_m1
);
  localparam int LAT = $clog2(K_STEPS) + 1;

  logic [7:0] inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 8'(in_valid && in_ready) - 8'(out_valid && out_ready);
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_m0) && $stable(out_m1)); // R1

  AST_INFLIGHT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    32'(inflight) <= LAT); // R2

  AST_NO_PHANTOM: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> inflight != 8'd0); // R7

  always @(posedge clk) begin
    if (rst_n && out_valid) begin
      for (int k = 1; k < K_STEPS; k++) begin
        AST_GLOBAL_MIN: assert (mmin(out_m0[k*MW +: MW], out_m1[k*MW +: MW]) ==
                                mmin(out_m0[0 +: MW], out_m1[0 +: MW]))
          else $error("global minimum differs at step %0d", k); // R9
      end
    end
  end
endmodule

bind tree_siso tsiso_checks #(.K_STEPS(K_STEPS)) u_checks (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_m0(out_m0), .out_m1(out_m1)
);

// File: tb/tree_siso_tb.sv
module tree_siso_tb;
  localparam int K   = 8;
  localparam int W   = 8;
  localparam int BMW = K * 4 * W;
  localparam int OW  = K * W;
  localparam int LAT = 4;
  localparam int NV  = 8;
  // entry: kind in [31:24], seed in [23:0]
  // kinds: 0 zero, 1 favour bit 1, 2 saturating, 3 random full, 4 random small, 5 start trap
  localparam logic [31:0] TABLE [NV] = '{
    32'h00_000000, 32'h01_000000, 32'h02_000000, 32'h03_00a5c3,
    32'h04_001234, 32'h05_00beef, 32'h03_777777, 32'h04_0f0f0f
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [BMW-1:0] in_bm = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [OW-1:0] out_m0, out_m1;

  int checks = 0;
  int errors = 0;
  logic [OW-1:0] exp0 [64];
  logic [OW-1:0] exp1 [64];
  int            expk [64];
  int wr = 0;
  int rd = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tree_siso #(.K_STEPS(K)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_bm(in_bm),
    .out_valid(out_valid), .out_ready(out_ready), .out_m0(out_m0), .out_m1(out_m1)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int x);
    return (x > 255) ? 255 : x;
  endfunction

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  // R3 layout: metric of step k, from state i to j, at bits (k*4+i*2+j)*8
  function automatic logic [BMW-1:0] gen_bm(input logic [31:0] entry);
    logic [BMW-1:0] v;
    logic [31:0] s;
    int kind, m;
    kind = int'(entry[31:24]);
    s = {8'h0, entry[23:0]} + 32'd1;
    for (int k = 0; k < K; k++)
      for (int i = 0; i < 2; i++)
        for (int j = 0; j < 2; j++) begin
          s = s * 32'd1103515245 + 32'd12345;
          case (kind)
            0: m = 0;
            1: m = (j == 1) ? 0 : 5;
            2: m = 200;
            3: m = int'(s[23:16]);
            4: m = int'(s[19:16]);
            default: m = (k == 0) ? ((i == 0) ? 100 : 0) : int'(s[19:16]);
          endcase
          v[(k*4 + i*2 + j)*W +: W] = W'(m);
        end
    return v;
  endfunction

  // serial forward/backward reference with saturation
  task automatic ref_model(input logic [BMW-1:0] bm, output logic [OW-1:0] m0,
                           output logic [OW-1:0] m1);
    int a [K+1][2];
    int b [K+1][2];
    int w;
    a[0][0] = 0; a[0][1] = 255;
    for (int k = 0; k < K; k++)
      for (int j = 0; j < 2; j++) begin
        a[k+1][j] = 255;
        for (int i = 0; i < 2; i++) begin
          w = int'(bm[(k*4 + i*2 + j)*W +: W]);
          a[k+1][j] = imin(a[k+1][j], sat(a[k][i] + w));
        end
      end
    b[K][0] = 0; b[K][1] = 0;
    for (int k = K - 1; k >= 0; k--)
      for (int i = 0; i < 2; i++) begin
        b[k][i] = 255;
        for (int j = 0; j < 2; j++) begin
          w = int'(bm[(k*4 + i*2 + j)*W +: W]);
          b[k][i] = imin(b[k][i], sat(w + b[k+1][j]));
        end
      end
    for (int k = 0; k < K; k++)
      for (int bit_v = 0; bit_v < 2; bit_v++) begin
        int best;
        best = 255;
        for (int i = 0; i < 2; i++) begin
          w = int'(bm[(k*4 + i*2 + bit_v)*W +: W]);
          best = imin(best, sat(sat(a[k][i] + w) + b[k+1][bit_v]));
        end
        if (bit_v == 0) m0[k*W +: W] = W'(best);
        else            m1[k*W +: W] = W'(best);
      end
  endtask

  // called at negedge+1; returns at negedge+1 after the accepting edge
  task automatic push(input logic [31:0] entry, output int waits);
    logic [OW-1:0] e0, e1;
    waits = 0;
    in_bm = gen_bm(entry);
    in_valid = 1'b1;
    while (!in_ready) begin
      @(negedge clk); #1;
      waits++;
    end
    ref_model(in_bm, e0, e1);
    exp0[wr % 64] = e0;
    exp1[wr % 64] = e1;
    expk[wr % 64] = int'(entry[31:24]);
    wr++;
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  // result monitor, samples at negedge+2
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready && !done) begin
      int kind;
      logic ok;
      kind = expk[rd % 64];
      check({out_m1, out_m0} == {exp1[rd % 64], exp0[rd % 64]}, "R3 R4",
            "block result vs serial reference", {out_m1, out_m0},
            {exp1[rd % 64], exp0[rd % 64]});
      ok = 1'b1;
      for (int k = 1; k < K; k++)
        if (imin(int'(out_m0[k*W +: W]), int'(out_m1[k*W +: W])) !=
            imin(int'(out_m0[0 +: W]), int'(out_m1[0 +: W]))) ok = 1'b0;
      check(ok, "R9", "per-step global minimum agrees", {out_m1, out_m0}, '0);
      if (kind == 1)
        check(out_m0 == {K{8'd5}} && out_m1 == '0, "R4", "favour-one pattern",
              {out_m1, out_m0}, {{K{8'd0}}, {K{8'd5}}});
      if (kind == 2)
        check(out_m0 == '1 && out_m1 == '1, "R6", "saturation at 255",
              {out_m1, out_m0}, {2*OW{1'b1}});
      if (kind == 5)
        check(out_m0[0 +: W] >= 8'd100 && out_m1[0 +: W] >= 8'd100, "R5",
              "start state pinned to 0", {out_m1[0 +: W], out_m0[0 +: W]}, {8'd100, 8'd100});
      rd++;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int waits, lat, total_waits;
    logic [OW-1:0] h0, h1;
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R8", "out_valid in reset", {127'd0, out_valid}, '0);
    check(in_ready == 1'b1, "R8", "in_ready in reset", {127'd0, in_ready}, 128'd1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R8", "out_valid after reset", {127'd0, out_valid}, '0);

    // R2 latency with a single block
    push(32'h04_00abcd, waits);
    lat = 1;
    while (!out_valid && lat < 20) begin
      @(negedge clk); #1;
      lat++;
    end
    check(lat == LAT, "R2", "latency in cycles", 128'(lat), 128'(LAT));
    repeat (6) @(negedge clk);
    #1;

    // table walked back to back, one block per cycle (R2)
    total_waits = 0;
    for (int n = 0; n < NV; n++) begin
      push(TABLE[n], waits);
      total_waits += waits;
    end
    check(total_waits == 0, "R2", "one block accepted per cycle", 128'(total_waits), '0);
    repeat (8) @(negedge clk);
    #1;

    // back-pressure (R1)
    out_ready = 1'b0;
    push(32'h03_135790, waits);
    push(32'h04_246802, waits);
    lat = 0;
    while (!out_valid && lat < 20) begin
      @(negedge clk); #1;
      lat++;
    end
    h0 = out_m0;
    h1 = out_m1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #1;
      check(out_valid && !in_ready, "R1", "valid held, input blocked",
            {126'd0, out_valid, in_ready}, 128'd2);
      check(out_m0 == h0 && out_m1 == h1, "R1", "result stable under stall",
            {out_m1, out_m0}, {h1, h0});
    end
    out_ready = 1'b1;
    repeat (10) @(negedge clk);
    #3;
    check(rd == wr, "R7", "one result per accepted block, in order", 128'(rd), 128'(wr));
    finish_run();
  end
endmodule